// File: doc/BRIEF.md
# Tape unit command sequencer

This block sits between a data channel and a group of up to fifteen magnetic tape drives (ten by default). It accepts select commands, decides at once whether each can run, and then paces the accepted operation with a single shared cycle timer. The operations are read, write, backspace one record, backspace to the previous file boundary, write a file mark, rewind, rewind-and-unload, set density and a no-operation. While a read or write runs it issues one word request per word slot, marks the last read word as end-of-record, and chains straight into another record while the channel stays connected.

The tape medium itself, the character conversion and the data path are outside the block. The medium reports the outcome of each motion on a small status code, and the sequencer turns that code into channel flags (file mark, load point, trace) and an optional disconnect. A rewind or unload frees the controller quickly. The drive stays busy in its own per-unit timer until the motion is done, so another drive can be used in the meantime.

Top module: `tape_seq`

## Requirements
- R1: A select with command code 0 is answered ILLEGAL (response 4). Otherwise a unit field (address bits 3:0) of 0 or above NUNIT is answered NODEV (response 2). The illegal check takes precedence.
- R2: A select of a legal, existing unit is answered STALL (response 1) and has no effect while the controller is busy or that unit still has a rewind/unload pending. A select is accepted (response 0) only from an idle controller. The response appears on `sel_resp` with `sel_resp_valid` one cycle after the select.
- R3: Commands 1, 2, 4, 5 and 8 to 13 are answered REFUSED (response 3) when the unit's `unit_loaded` bit (bit u-1) is low.
- R4: Commands 2, 5, 8 and 9 are answered REFUSED (response 3) when the unit's `unit_wprot` bit is high.
- R5: Read (command 1 or 10): CYC_START cycles after acceptance the medium status and the word count `med_words` are sampled (0 counts as 1). Word k of the record is requested on `rd_req` at CYC_START + k*CYC_WORD. The last word also raises `rd_eor`.
- R6: CYC_STOP cycles after the last read word, the sequencer checks `chan_conn`. If it is high, the next record is sampled CYC_SHORT cycles later. If it is low, `ctl_busy` falls.
- R7: Write (command 2 or 8): `wr_req` pulses CYC_START cycles after acceptance and then every CYC_WORD cycles. At each slot after the first, `io_check` pulses if `chan_word_ok` was not seen since the previous slot.
- R8: During a write, `chan_eor` or a dropped `chan_conn` at a slot pulses `wr_commit` and starts a CYC_STOP stop phase. The stop phase chains to a new record (after CYC_SHORT) while connected, and otherwise leaves `ctl_busy` low.
- R9: Rewind (6) and unload (7) pulse `chan_disc` and release `ctl_busy` CYC_SHORT cycles after acceptance. CYC_START cycles later the unit's bit pulses on `rew_done` or `unload_done`. Until then the unit stalls.
- R10: Set density (3) makes `den_high` of the unit equal to address bit 4, CYC_SHORT cycles after acceptance, with a disconnect. A rising `unit_loaded` bit forces that unit's `den_high` to 1.
- R11: Medium status codes: 0 ok, 1 tape mark, 2 end of medium, 3 write protect, 4 record error, 5 load point, 6 I/O error. Codes 1 and 2 give `flag_eof` and a disconnect. Code 3 gives a disconnect with no flag. Code 4 gives `flag_trace` and no disconnect. Code 5 gives `flag_bot`. Code 6 gives `flag_trace` and a disconnect.
- R12: A backspace (4, 11, 12, 13) that ends with status 1 disconnects without `flag_eof`.
- R13: Write file mark (5 or 9) disconnects CYC_WEF cycles after acceptance, with flags from the status sampled then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_valid | input | 1 | Select command strobe |
| sel_cmd | input | 4 | Command code |
| sel_addr | input | 5 | Bits 3:0 unit number, bit 4 density/mode bit |
| unit_loaded | input | NUNIT | Per-unit loaded (attached) state, bit u-1 |
| unit_wprot | input | NUNIT | Per-unit write protect, bit u-1 |
| chan_conn | input | 1 | Channel still connected |
| chan_word_ok | input | 1 | Channel delivered a write word |
| chan_eor | input | 1 | Channel ends the write record |
| med_status | input | 3 | Medium outcome code (R11) |
| med_words | input | LEN_W | Words in the record being read |
| sel_resp_valid | output | 1 | Select response strobe |
| sel_resp | output | 3 | 0 accept, 1 stall, 2 nodev, 3 refused, 4 illegal |
| ctl_busy | output | 1 | Controller busy |
| act_cmd | output | 4 | Command being run |
| act_unit | output | 4 | Unit being run |
| rd_req | output | 1 | Read word request pulse |
| rd_eor | output | 1 | Last read word of record |
| wr_req | output | 1 | Write word request pulse |
| wr_commit | output | 1 | Write record committed |
| io_check | output | 1 | Late write word |
| flag_eof | output | 1 | File mark / end of medium flag |
| flag_bot | output | 1 | Load point flag |
| flag_trace | output | 1 | Error trace flag |
| chan_disc | output | 1 | Disconnect the channel |
| rew_done | output | NUNIT | Rewind finished, per unit |
| unload_done | output | NUNIT | Unload finished, per unit |
| den_high | output | NUNIT | Unit density is high |

## Verification
A vector table walks the select checks. It covers illegal codes, missing units with and without the mode bit, unloaded drives and protected drives against write-class commands, so that each refusal cause is told apart from the others and from precedence mistakes. Directed runs then drive reads of several record lengths with chaining and a late disconnect, and writes with a skipped word and a channel end-of-record. Each medium status code is applied to the operation class where its mapping differs, which separates "flag and continue" from "flag and disconnect" and from the backspace tape-mark exemption. Rewind, unload and density commands check the early release, the per-unit stall and the delayed per-unit completion.

// File: rtl/tape_seq_pkg.sv
package tape_seq_pkg;

   typedef enum logic [2:0] {
      RSP_OK = 3'd0, RSP_STALL = 3'd1, RSP_NODEV = 3'd2,
      RSP_REFUSE = 3'd3, RSP_ILLEGAL = 3'd4
   } rsp_e;

   typedef enum logic [3:0] {
      OPK_NOP, OPK_READ, OPK_WRITE, OPK_BKREC, OPK_BKFILE,
      OPK_WEOF, OPK_REW, OPK_UNLOAD, OPK_DEN
   } opk_e;

   typedef enum logic [3:0] {
      S_IDLE, S_RD_GO, S_RD_WORD, S_RD_STOP,
      S_WR_GO, S_WR_WORD, S_WR_STOP, S_MOTION, S_QUICK
   } st_e;

   localparam logic [2:0] MS_TMARK  = 3'd1;
   localparam logic [2:0] MS_EOM    = 3'd2;
   localparam logic [2:0] MS_WPROT  = 3'd3;
   localparam logic [2:0] MS_RECERR = 3'd4;
   localparam logic [2:0] MS_BOT    = 3'd5;
   localparam logic [2:0] MS_IOERR  = 3'd6;

   // per command code: needs a loaded unit / writes to tape
   localparam logic [15:0] NEEDS_LOAD = 16'h3F36;
   localparam logic [15:0] WRITES     = 16'h0324;

   typedef struct packed {
      logic eof;
      logic bot;
      logic trace;
      logic abort;
   } sres_t;

   function automatic opk_e op_kind(input logic [3:0] c);
      case (c)
         4'd1, 4'd10: return OPK_READ;
         4'd2, 4'd8:  return OPK_WRITE;
         4'd4, 4'd12: return OPK_BKREC;
         4'd11, 4'd13: return OPK_BKFILE;
         4'd5, 4'd9:  return OPK_WEOF;
         4'd6:        return OPK_REW;
         4'd7:        return OPK_UNLOAD;
         4'd3:        return OPK_DEN;
         default:     return OPK_NOP;
      endcase
   endfunction

   function automatic sres_t map_status(input logic [2:0] s);
      sres_t r;
      r = '0;
      case (s)
         MS_TMARK, MS_EOM: begin r.eof = 1'b1; r.abort = 1'b1; end
         MS_WPROT:         r.abort = 1'b1;
         MS_RECERR:        r.trace = 1'b1;
         MS_BOT:           r.bot = 1'b1;
         MS_IOERR:         begin r.trace = 1'b1; r.abort = 1'b1; end
         default:          r = '0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/tape_seq_timer.sv
module tape_seq_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] val,
   output logic          expire,
   output logic          active
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= val;
      else if (cnt != '0)  cnt <= cnt - TW'(1);
   end

   assign expire = (cnt == TW'(1));
   assign active = (cnt != '0);
endmodule

// File: rtl/tape_seq_unit.sv
module tape_seq_unit #(
   parameter int TW        = 16,
   parameter int CYC_START = 29000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic loaded,
   input  logic arm,
   input  logic arm_unload,
   input  logic den_wr,
   input  logic den_val,
   output logic pending,
   output logic den_high,
   output logic rew_done,
   output logic unl_done
);
   logic expire;
   logic kind_unl;
   logic loaded_q;

   tape_seq_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(arm), .val(TW'(CYC_START)),
      .expire(expire), .active(pending)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         den_high <= 1'b0;
         loaded_q <= 1'b0;
         kind_unl <= 1'b0;
         rew_done <= 1'b0;
         unl_done <= 1'b0;
      end else begin
         loaded_q <= loaded;
         if (loaded && !loaded_q) den_high <= 1'b1;
         else if (den_wr)         den_high <= den_val;
         if (arm) kind_unl <= arm_unload;
         rew_done <= expire && !kind_unl;
         unl_done <= expire && kind_unl;
      end
   end
endmodule

// File: rtl/tape_seq_gate.sv
module tape_seq_gate
   import tape_seq_pkg::*;
#(
   parameter int NUNIT = 10
) (
   input  logic [3:0]       cmd,
   input  logic [3:0]       unit,
   input  logic             busy,
   input  logic [NUNIT-1:0] pending,
   input  logic [NUNIT-1:0] loaded,
   input  logic [NUNIT-1:0] wprot,
   output rsp_e             rsp
);
   logic [15:0] pend_x, load_x, wp_x;
   logic [3:0]  idx;

   always_comb begin
      pend_x = 16'(pending);
      load_x = 16'(loaded);
      wp_x   = 16'(wprot);
      idx    = unit - 4'd1;
      if (cmd == 4'd0)                                 rsp = RSP_ILLEGAL;
      else if (unit == 4'd0 || unit > 4'(NUNIT))       rsp = RSP_NODEV;
      else if (busy || pend_x[idx])                    rsp = RSP_STALL;
      else if (NEEDS_LOAD[cmd] && !load_x[idx])        rsp = RSP_REFUSE;
      else if (WRITES[cmd] && wp_x[idx])               rsp = RSP_REFUSE;
      else                                             rsp = RSP_OK;
   end
endmodule

// File: rtl/tape_seq.sv
module tape_seq
   import tape_seq_pkg::*;
#(
   parameter int NUNIT     = 10,
   parameter int LEN_W     = 8,
   parameter int CYC_WEF   = 25000,
   parameter int CYC_START = 29000,
   parameter int CYC_STOP  = 10000,
   parameter int CYC_WORD  = 50,
   parameter int CYC_SHORT = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_valid,
   input  logic [3:0]       sel_cmd,
   input  logic [4:0]       sel_addr,
   input  logic [NUNIT-1:0] unit_loaded,
   input  logic [NUNIT-1:0] unit_wprot,
   input  logic             chan_conn,
   input  logic             chan_word_ok,
   input  logic             chan_eor,
   input  logic [2:0]       med_status,
   input  logic [LEN_W-1:0] med_words,
   output logic             sel_resp_valid,
   output logic [2:0]       sel_resp,
   output logic             ctl_busy,
   output logic [3:0]       act_cmd,
   output logic [3:0]       act_unit,
   output logic             rd_req,
   output logic             rd_eor,
   output logic             wr_req,
   output logic             wr_commit,
   output logic             io_check,
   output logic             flag_eof,
   output logic             flag_bot,
   output logic             flag_trace,
   output logic             chan_disc,
   output logic [NUNIT-1:0] rew_done,
   output logic [NUNIT-1:0] unload_done,
   output logic [NUNIT-1:0] den_high
);
   localparam int MX_A = (CYC_START > CYC_WEF) ? CYC_START : CYC_WEF;
   localparam int MX_B = (CYC_STOP > CYC_SHORT) ? CYC_STOP : CYC_SHORT;
   localparam int MX_C = (MX_B > CYC_WORD) ? MX_B : CYC_WORD;
   localparam int MX   = (MX_A > MX_C) ? MX_A : MX_C;
   localparam int TW   = $clog2(MX + 1);

   if (NUNIT < 1 || NUNIT > 15) begin : g_bad_nunit
      $error("NUNIT must be 1..15");
   end
   if (LEN_W < 1 || CYC_WEF < 1 || CYC_START < 1 || CYC_STOP < 1 ||
       CYC_WORD < 1 || CYC_SHORT < 1) begin : g_bad_delay
      $error("widths and delays must be at least 1");
   end

   st_e   st, st_n;
   opk_e  op;
   rsp_e  rsp;
   sres_t sres;
   logic  cur_hi, got, got_n, accept, tm_load, tm_exp, tm_act;
   logic  arm, den_wr;
   logic  p_rd, p_eor, p_wr, p_commit, p_ioc, p_eof, p_bot, p_trc, p_disc;
   logic [TW-1:0]    tm_val;
   logic [LEN_W-1:0] words, words_n;
   logic [NUNIT-1:0] pending;

   tape_seq_gate #(.NUNIT(NUNIT)) u_gate (
      .cmd(sel_cmd), .unit(sel_addr[3:0]), .busy(ctl_busy), .pending(pending),
      .loaded(unit_loaded), .wprot(unit_wprot), .rsp(rsp)
   );

   tape_seq_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tm_load), .val(tm_val),
      .expire(tm_exp), .active(tm_act)
   );

   for (genvar i = 0; i < NUNIT; i++) begin : g_unit
      tape_seq_unit #(.TW(TW), .CYC_START(CYC_START)) u_unit (
         .clk(clk), .rst_n(rst_n), .loaded(unit_loaded[i]),
         .arm(arm && act_unit == 4'(i + 1)), .arm_unload(op == OPK_UNLOAD),
         .den_wr(den_wr && act_unit == 4'(i + 1)), .den_val(cur_hi),
         .pending(pending[i]), .den_high(den_high[i]),
         .rew_done(rew_done[i]), .unl_done(unload_done[i])
      );
   end

   assign ctl_busy = (st != S_IDLE);
   assign accept   = sel_valid && (rsp == RSP_OK);
   assign sres     = map_status(med_status);

   always_comb begin
      st_n = st; tm_load = 1'b0; tm_val = '0; words_n = words;
      got_n = got || (st == S_WR_WORD && chan_word_ok);
      {p_rd, p_eor, p_wr, p_commit, p_ioc, p_eof, p_bot, p_trc, p_disc} = '0;
      arm = 1'b0; den_wr = 1'b0;
      unique case (st)
         S_IDLE: if (accept) begin
            tm_load = 1'b1;
            unique case (op_kind(sel_cmd))
               OPK_READ:            begin st_n = S_RD_GO;  tm_val = TW'(CYC_START); end
               OPK_WRITE:           begin st_n = S_WR_GO;  tm_val = TW'(CYC_START); end
               OPK_BKREC, OPK_BKFILE: begin st_n = S_MOTION; tm_val = TW'(CYC_START); end
               OPK_WEOF:            begin st_n = S_MOTION; tm_val = TW'(CYC_WEF); end
               default:             begin st_n = S_QUICK;  tm_val = TW'(CYC_SHORT); end
            endcase
         end
         S_RD_GO: if (tm_exp) begin
            {p_eof, p_bot, p_trc} = {sres.eof, sres.bot, sres.trace};
            if (sres.abort) begin p_disc = 1'b1; st_n = S_IDLE; end
            else if (!chan_conn) st_n = S_IDLE;
            else begin
               words_n = (med_words == '0) ? LEN_W'(1) : med_words;
               st_n = S_RD_WORD; tm_load = 1'b1; tm_val = TW'(CYC_WORD);
            end
         end
         S_RD_WORD: if (tm_exp) begin
            p_rd = 1'b1; tm_load = 1'b1;
            if (words <= LEN_W'(1)) begin
               p_eor = 1'b1; st_n = S_RD_STOP; tm_val = TW'(CYC_STOP);
            end else begin
               words_n = words - LEN_W'(1); tm_val = TW'(CYC_WORD);
            end
         end
         S_RD_STOP, S_WR_STOP: if (tm_exp) begin
            if (chan_conn) begin
               st_n = (st == S_RD_STOP) ? S_RD_GO : S_WR_GO;
               tm_load = 1'b1; tm_val = TW'(CYC_SHORT);
            end else st_n = S_IDLE;
         end
         S_WR_GO: if (tm_exp) begin
            if (!chan_conn) st_n = S_IDLE;
            else begin
               p_wr = 1'b1; got_n = 1'b0; st_n = S_WR_WORD;
               tm_load = 1'b1; tm_val = TW'(CYC_WORD);
            end
         end
         S_WR_WORD: begin
            if (chan_eor || (tm_exp && !chan_conn)) begin
               p_commit = 1'b1; st_n = S_WR_STOP;
               tm_load = 1'b1; tm_val = TW'(CYC_STOP);
            end else if (tm_exp) begin
               p_ioc = !got_n; p_wr = 1'b1; got_n = 1'b0;
               tm_load = 1'b1; tm_val = TW'(CYC_WORD);
            end
         end
         S_MOTION: if (tm_exp) begin
            st_n = S_IDLE; p_disc = 1'b1;
            if (!((op == OPK_BKREC || op == OPK_BKFILE) && med_status == MS_TMARK))
               {p_eof, p_bot, p_trc} = {sres.eof, sres.bot, sres.trace};
         end
         S_QUICK: if (tm_exp) begin
            st_n = S_IDLE; p_disc = 1'b1;
            arm = (op == OPK_REW) || (op == OPK_UNLOAD);
            den_wr = (op == OPK_DEN);
         end
         default: st_n = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= S_IDLE; op <= OPK_NOP; act_cmd <= '0; act_unit <= '0; cur_hi <= 1'b0;
         words <= '0; got <= 1'b0; sel_resp_valid <= 1'b0; sel_resp <= '0;
         {rd_req, rd_eor, wr_req, wr_commit, io_check} <= '0;
         {flag_eof, flag_bot, flag_trace, chan_disc} <= '0;
      end else begin
         st <= st_n; words <= words_n; got <= got_n;
         sel_resp_valid <= sel_valid;
         sel_resp <= rsp;
         if (accept) begin
            op <= op_kind(sel_cmd); act_cmd <= sel_cmd;
            act_unit <= sel_addr[3:0]; cur_hi <= sel_addr[4];
         end
         {rd_req, rd_eor, wr_req, wr_commit, io_check} <= {p_rd, p_eor, p_wr, p_commit, p_ioc};
         {flag_eof, flag_bot, flag_trace, chan_disc} <= {p_eof, p_bot, p_trc, p_disc};
      end
   end

   logic unused_ok;
   assign unused_ok = tm_act;
endmodule

// File: rtl/tape_seq_sva.sv
module tape_seq_sva #(
   parameter int NUNIT = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       sel_cmd,
   input logic             sel_resp_valid,
   input logic [2:0]       sel_resp,
   input logic             ctl_busy,
   input logic             rd_req,
   input logic             rd_eor,
   input logic             wr_req,
   input logic             io_check,
   input logic             flag_eof,
   input logic             chan_disc,
   input logic [NUNIT-1:0] rew_done,
   input logic [NUNIT-1:0] unload_done
);
   assert_illegal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_resp_valid && $past(sel_cmd) == 4'd0) |-> sel_resp == 3'd4);

   assert_accept_only_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_resp_valid && sel_resp == 3'd0) |-> !$past(ctl_busy));

   assert_eor_on_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_eor |-> rd_req);

   assert_read_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> ctl_busy);

   assert_ioc_at_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      io_check |-> wr_req);

   assert_done_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rew_done & unload_done) == '0);

   assert_eof_disconnects_R11: assert property (@(posedge clk) disable iff (!rst_n)
      flag_eof |-> chan_disc);
endmodule

bind tape_seq tape_seq_sva #(.NUNIT(NUNIT)) u_sva (
   .clk(clk), .rst_n(rst_n), .sel_cmd(sel_cmd), .sel_resp_valid(sel_resp_valid),
   .sel_resp(sel_resp), .ctl_busy(ctl_busy), .rd_req(rd_req), .rd_eor(rd_eor),
   .wr_req(wr_req), .io_check(io_check), .flag_eof(flag_eof), .chan_disc(chan_disc),
   .rew_done(rew_done), .unload_done(unload_done)
);

// File: tb/tape_seq_tb_top.sv
module tape_seq_tb_top;
   localparam int NU = 10;
   localparam int LW = 8;
   localparam int T_WEF = 30, T_START = 40, T_STOP = 20, T_WORD = 6, T_SHORT = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sel_valid = 1'b0;
   logic [3:0] sel_cmd = '0;
   logic [4:0] sel_addr = '0;
   logic [NU-1:0] unit_loaded = 10'b0000001111;
   logic [NU-1:0] unit_wprot  = 10'b0000000100;
   logic chan_conn = 1'b0, chan_word_ok = 1'b0, chan_eor = 1'b0;
   logic [2:0] med_status = '0;
   logic [LW-1:0] med_words = 8'd3;
   logic sel_resp_valid, ctl_busy, rd_req, rd_eor, wr_req, wr_commit, io_check;
   logic flag_eof, flag_bot, flag_trace, chan_disc;
   logic [2:0] sel_resp;
   logic [3:0] act_cmd, act_unit;
   logic [NU-1:0] rew_done, unload_done, den_high;

   tape_seq #(.NUNIT(NU), .LEN_W(LW), .CYC_WEF(T_WEF), .CYC_START(T_START),
      .CYC_STOP(T_STOP), .CYC_WORD(T_WORD), .CYC_SHORT(T_SHORT)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_cmd(sel_cmd),
      .sel_addr(sel_addr), .unit_loaded(unit_loaded), .unit_wprot(unit_wprot),
      .chan_conn(chan_conn), .chan_word_ok(chan_word_ok), .chan_eor(chan_eor),
      .med_status(med_status), .med_words(med_words),
      .sel_resp_valid(sel_resp_valid), .sel_resp(sel_resp), .ctl_busy(ctl_busy),
      .act_cmd(act_cmd), .act_unit(act_unit), .rd_req(rd_req), .rd_eor(rd_eor),
      .wr_req(wr_req), .wr_commit(wr_commit), .io_check(io_check),
      .flag_eof(flag_eof), .flag_bot(flag_bot), .flag_trace(flag_trace),
      .chan_disc(chan_disc), .rew_done(rew_done), .unload_done(unload_done),
      .den_high(den_high)
   );

   always #4 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0, n_err = 0;
   int n_rd, t_rd_first, n_eor, t_eor, n_wr, n_ioc, t_ioc, n_commit, t_commit;
   int n_eof, n_bot, n_trc, n_disc, t_disc, t_rew, t_unl;
   logic [NU-1:0] v_rew, v_unl;

   task automatic clear_log();
      n_rd = 0; t_rd_first = 0; n_eor = 0; t_eor = 0; n_wr = 0; n_ioc = 0; t_ioc = 0;
      n_commit = 0; t_commit = 0; n_eof = 0; n_bot = 0; n_trc = 0; n_disc = 0;
      t_disc = 0; t_rew = 0; t_unl = 0; v_rew = '0; v_unl = '0;
   endtask

   always @(negedge clk) if (rst_n) begin
      if (rd_req) begin if (n_rd == 0) t_rd_first = cyc; n_rd = n_rd + 1; end
      if (rd_eor) begin n_eor = n_eor + 1; t_eor = cyc; end
      if (wr_req) n_wr = n_wr + 1;
      if (io_check) begin n_ioc = n_ioc + 1; t_ioc = cyc; end
      if (wr_commit) begin n_commit = n_commit + 1; t_commit = cyc; end
      if (flag_eof) n_eof = n_eof + 1;
      if (flag_bot) n_bot = n_bot + 1;
      if (flag_trace) n_trc = n_trc + 1;
      if (chan_disc) begin n_disc = n_disc + 1; t_disc = cyc; end
      if (rew_done != '0) begin t_rew = cyc; v_rew = rew_done; end
      if (unload_done != '0) begin t_unl = cyc; v_unl = unload_done; end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
      #1;
   endtask

   // select: returns cycle stamp of the select edge and the response
   task automatic do_sel(input logic [3:0] c, input logic [4:0] a,
                         output int t0, output int r);
      @(negedge clk);
      sel_valid = 1'b1; sel_cmd = c; sel_addr = a;
      @(negedge clk);
      sel_valid = 1'b0;
      t0 = cyc;
      #1;
      r = sel_resp_valid ? int'(sel_resp) : -1;
   endtask

   task automatic pulse_word();
      chan_word_ok = 1'b1; @(negedge clk); chan_word_ok = 1'b0;
   endtask

   // {cmd, addr, expected response}
   localparam logic [11:0] VEC [10] = '{
      {4'd0,  5'd1,  3'd4}, {4'd0,  5'd0,  3'd4}, {4'd1,  5'd0,  3'd2},
      {4'd1,  5'd11, 3'd2}, {4'd7,  5'h10, 3'd2}, {4'd1,  5'd6,  3'd3},
      {4'd8,  5'd6,  3'd3}, {4'd12, 5'd7,  3'd3}, {4'd2,  5'd3,  3'd3},
      {4'd9,  5'd3,  3'd3}
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
   end

   initial begin : main
      int t0, t1, r;
      clear_log();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); @(negedge clk); #1;
      chk("reset busy R2", int'(ctl_busy), 0);
      chk("reset density of loaded units R10", int'(den_high), 32'h00F);

      // select checks from the table: R1 R3 R4
      for (int i = 0; i < 10; i++) begin
         do_sel(VEC[i][11:8], VEC[i][7:3], t0, r);
         chk($sformatf("select vector %0d R1/R3/R4", i), r, int'(VEC[i][2:0]));
      end
      chk("no activity after refusals R3 R4", int'(ctl_busy) + n_disc, 0);

      // read with chaining: R5 R6 R2
      clear_log(); chan_conn = 1'b1; med_status = 3'd0; med_words = 8'd3;
      do_sel(4'd1, 5'd1, t0, r);
      chk("read accepted R2", r, 0);
      wait_until(t0 + 20);
      do_sel(4'd1, 5'd2, t1, r);
      chk("select while busy stalls R2", r, 1);
      wait_until(t0 + 70); med_words = 8'd2;
      wait_until(t0 + 105); chan_conn = 1'b0;
      chk("first read word time R5", t_rd_first - t0, T_START + T_WORD);
      wait_until(t0 + 110);
      chk("busy during second stop R6", int'(ctl_busy), 1);
      wait_until(t0 + 125);
      chk("read word count over two records R5", n_rd, 5);
      chk("eor count R5", n_eor, 2);
      chk("chained eor time R6", t_eor - t0, 2*T_START - T_START + T_WORD*3 + T_STOP + T_SHORT + 2*T_WORD);
      chk("busy clears without channel R6", int'(ctl_busy), 0);

      // read with record error: trace, no disconnect R11
      clear_log(); chan_conn = 1'b1; med_status = 3'd4; med_words = 8'd2;
      do_sel(4'd10, 5'd2, t0, r);
      wait_until(t0 + 50); chan_conn = 1'b0;
      wait_until(t0 + 80);
      chk("record error trace R11", n_trc, 1);
      chk("record error no disconnect R11", n_disc, 0);
      chk("record error words still read R11", n_rd, 2);

      // read with I/O error: trace and disconnect R11
      clear_log(); chan_conn = 1'b1; med_status = 3'd6;
      do_sel(4'd1, 5'd1, t0, r);
      wait_until(t0 + T_START + 3);
      chk("io error trace R11", n_trc, 1);
      chk("io error disconnect R11", n_disc, 1);
      chk("io error no words R11", n_rd, 0);
      chk("io error idle R11", int'(ctl_busy), 0);

      // read hitting a tape mark R11
      clear_log(); med_status = 3'd1;
      do_sel(4'd1, 5'd1, t0, r);
      wait_until(t0 + T_START + 3);
      chk("tape mark eof flag R11", n_eof, 1);
      chk("tape mark disconnect R11", n_disc, 1);

      // write with a missed word and channel end-of-record: R7 R8
      clear_log(); med_status = 3'd0; chan_conn = 1'b1;
      do_sel(4'd2, 5'd1, t0, r);
      chk("write accepted R4", r, 0);
      wait_until(t0 + 42); pulse_word();
      wait_until(t0 + 55); pulse_word();
      wait_until(t0 + 58); chan_eor = 1'b1; @(negedge clk); chan_eor = 1'b0;
      wait_until(t0 + 60); chan_conn = 1'b0;
      wait_until(t0 + 85);
      chk("write slots R7", n_wr, 4);
      chk("late word io check count R7", n_ioc, 1);
      chk("late word io check time R7", t_ioc - t0, T_START + 2*T_WORD);
      chk("commit time R8", t_commit - t0, T_START + 3*T_WORD + 1);
      chk("write stop ends idle R8", int'(ctl_busy), 0);

      // write file mark: R13, and write-protect status R11
      clear_log(); med_status = 3'd0;
      do_sel(4'd5, 5'd1, t0, r);
      wait_until(t0 + T_WEF + 2);
      chk("file mark disconnect time R13", t_disc - t0, T_WEF);
      clear_log(); med_status = 3'd3;
      do_sel(4'd9, 5'd2, t0, r);
      wait_until(t0 + T_WEF + 2);
      chk("write protect disconnect R11", n_disc, 1);
      chk("write protect no flags R11", n_eof + n_trc + n_bot, 0);

      // backspace stopping on tape mark R12, and on load point R11
      clear_log(); med_status = 3'd1;
      do_sel(4'd4, 5'd1, t0, r);
      wait_until(t0 + T_START + 2);
      chk("backspace tape mark disconnect R12", t_disc - t0, T_START);
      chk("backspace tape mark no eof R12", n_eof, 0);
      clear_log(); med_status = 3'd5;
      do_sel(4'd12, 5'd1, t0, r);
      wait_until(t0 + T_START + 2);
      chk("load point flag R11", n_bot, 1);
      med_status = 3'd0;

      // rewind and unload: R9
      clear_log();
      do_sel(4'd6, 5'd4, t0, r);
      wait_until(t0 + T_SHORT + 2);
      chk("rewind early release R9", t_disc - t0, T_SHORT);
      chk("rewind controller free R9", int'(ctl_busy), 0);
      do_sel(4'd1, 5'd4, t1, r);
      chk("rewinding unit stalls R9", r, 1);
      wait_until(t0 + T_SHORT + T_START + 2);
      chk("rewind done time R9", t_rew - t0, T_SHORT + T_START);
      chk("rewind done unit R9", int'(v_rew), 32'h008);
      clear_log();
      do_sel(4'd7, 5'd5, t0, r);
      wait_until(t0 + T_SHORT + T_START + 2);
      chk("unload done unit R9", int'(v_unl), 32'h010);
      chk("unload not a rewind R9", int'(v_rew), 0);

      // set density and attach: R10
      do_sel(4'd3, 5'd2, t0, r);
      wait_until(t0 + T_SHORT + 1);
      chk("density low R10", int'(den_high[1]), 0);
      do_sel(4'd3, 5'h12, t0, r);
      wait_until(t0 + T_SHORT + 1);
      chk("density high R10", int'(den_high[1]), 1);
      chk("unit 6 starts low R10", int'(den_high[5]), 0);
      @(negedge clk); unit_loaded[5] = 1'b1;
      @(negedge clk); @(negedge clk); #1;
      chk("attach forces high R10", int'(den_high[5]), 1);

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule